// File: doc/BRIEF.md
# Half-Word Selectable Operand Store

This block is the shared operand memory of a multiprocessor. Its words are 68 bits wide, and each word is handled as two 34-bit halves. Each half holds 32 data bits and 2 parity bits that the store generates itself. One instruction-fetch port, a set of processor operand ports and a set of I/O controller ports compete for the array. A fixed-priority arbiter serves them, and each access holds the array for a fixed number of clocks.

Every request names the left half, the right half or the whole word. The operand ports and the I/O ports may store and fetch data, and they may also store instructions. A store marked as an instruction sets a per-word tag. From then on, only the instruction-fetch port may read that word back. A data port that fetches a tagged word receives an access-violation flag and a blanked result.

The full-size store uses `ADDR_W = 14` (16384 words). A smaller default is used so that elaboration stays light. Every width, port count and the busy time are parameters.

Top module: `halfsel_operand_store`

## Requirements
- R1: After reset, no grant and no response is active, and every word is untagged. A reset clears the tags but does not clear the array contents.
- R2: Parity and word layout:
  - A whole-word store writes `wdata[63:32]` into the left half (word bits 67:34) and `wdata[31:0]` into the right half (word bits 33:0).
  - Each stored half is laid out as `{par[1:0], data[31:0]}`, where `par[j]` is the XOR of `data[16j+15:16j]`.
  - A whole-word fetch returns the 68-bit word as `{left, right}`.
- R3: A half store rewrites only the selected half and its parity; the other half keeps its old contents. The data for the left half is taken from `wdata[63:32]` and the data for the right half from `wdata[31:0]`.
- R4: The half select is encoded as 2'b10 = left, 2'b01 = right, 2'b11 = both. A half fetch returns the selected 34-bit half in `rsp_data[33:0]`, with `rsp_data[67:34]` zero.
- R5: Select value 2'b00 selects nothing. A store with it changes no data and no tag, and a fetch with it returns all zeros.
- R6: A store with a nonzero select sets the word's tag when `dp_ins` is 1 and clears it when `dp_ins` is 0.
- R7: Tagged words and fetch permissions:
  - A data port that fetches a tagged word gets `rsp_viol` = 1 and `rsp_data` = 0.
  - The instruction-fetch port fetches any word with `rsp_viol` = 0.
  - A fetch of an untagged word by any port gives `rsp_viol` = 0.
- R8: Fixed priority. When the array is idle, the instruction-fetch port wins first. After it, data ports win in ascending index order: operand ports are indices 0 to NUM_OPR-1 and I/O ports follow them. At most one grant is active, and only to a requesting port.
- R9: Busy time and waiting requests:
  - A grant in cycle t keeps the array busy through cycle t+BUSY_CYC-1, and no grant is given while it is busy.
  - The earliest next grant is in cycle t+BUSY_CYC.
  - A request that arrives while the array is busy waits, holding its fields, until it is granted.
- R10: Fetch responses:
  - A fetch granted in cycle t produces a one-cycle `rsp_valid` in cycle t+BUSY_CYC-1.
  - `rsp_port` is 0 for the instruction-fetch port and k+1 for data port k.
  - Stores produce no response.
- R11: A store is visible to the next access that follows it, from any port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| if_req | input | 1 | Instruction-fetch port request, held until granted |
| if_addr | input | ADDR_W | Instruction-fetch word address |
| if_sel | input | 2 | Instruction-fetch half select |
| dp_req | input | NDP | Data port requests (operand ports first, then I/O ports) |
| dp_we | input | NDP | Per data port: 1 = store, 0 = fetch |
| dp_ins | input | NDP | Per data port: the store is an instruction |
| dp_sel | input | NDP x 2 | Per data port half select |
| dp_addr | input | NDP x ADDR_W | Per data port word address |
| dp_wdata | input | NDP x 64 | Per data port store data, left data in the upper 32 bits |
| if_gnt | output | 1 | Instruction-fetch port granted this cycle |
| dp_gnt | output | NDP | Data port granted this cycle |
| rsp_valid | output | 1 | Fetch result valid |
| rsp_port | output | PID_W | Port that issued the fetch |
| rsp_viol | output | 1 | Access violation on a tagged word |
| rsp_data | output | 68 | Fetch result with parity |

## Verification
The store is tried with several kinds of data: whole-word writes and reads of varied bit patterns from every port, which expose parity slicing and half-order mistakes. It is also tried with half-word stores and fetches on words already filled, which show whether the untouched half survives and whether results are right-justified. Instruction-tagged stores are followed by fetches from data ports and from the instruction-fetch port, and then by data stores, to separate the tag set, tag clear and fetch-permission rules. All ports are also made to request at once, and late requests are made to arrive mid-access, to expose priority order and busy-window errors. A reset between an instruction store and its fetch shows whether the tags are cleared.

// File: rtl/hos_pkg.sv
package hos_pkg;
   // Half selection code carried by every request.
   typedef enum logic [1:0] {
      HS_NONE  = 2'b00,
      HS_RIGHT = 2'b01,
      HS_LEFT  = 2'b10,
      HS_BOTH  = 2'b11
   } half_sel_e;
endpackage

// File: rtl/hos_parity_gen.sv
module hos_parity_gen #(
   parameter int DW    = 32,
   parameter int SLICE = 16,
   localparam int NPAR = DW / SLICE
) (
   input  logic [DW-1:0]   data_i,
   output logic [NPAR-1:0] par_o
);
   if (DW % SLICE != 0) begin : g_err_slice
      $error("hos_parity_gen: DW must be a multiple of SLICE");
   end

   // One even-parity bit for each slice of the half.
   for (genvar j = 0; j < NPAR; j++) begin : g_slice
      assign par_o[j] = ^data_i[j*SLICE +: SLICE];
   end
endmodule

// File: rtl/hos_arbiter.sv
module hos_arbiter #(
   parameter int N = 5,
   localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic             en_i,
   input  logic [N-1:0]     req_i,
   output logic [N-1:0]     gnt_o,
   output logic [IDX_W-1:0] idx_o
);
   if (N < 2) begin : g_err_n
      $error("hos_arbiter: at least two requesters expected");
   end

   // Lowest index wins; each position is masked by all lower requests.
   for (genvar i = 0; i < N; i++) begin : g_pri
      if (i == 0) begin : g_top
         assign gnt_o[i] = en_i & req_i[i];
      end else begin : g_rest
         assign gnt_o[i] = en_i & req_i[i] & ~(|req_i[i-1:0]);
      end
   end

   always_comb begin
      idx_o = '0;
      for (int i = 0; i < N; i++) begin
         if (gnt_o[i]) idx_o = IDX_W'(i);
      end
   end
endmodule

// File: rtl/hos_bank.sv
module hos_bank
   import hos_pkg::*;
#(
   parameter int ADDR_W = 10,
   parameter int HALF_W = 34,
   localparam int DEPTH  = 1 << ADDR_W,
   localparam int WORD_W = 2 * HALF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_i,
   input  logic              we_i,
   input  logic              ins_i,
   input  logic              ifp_i,
   input  logic [1:0]        sel_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [WORD_W-1:0] wword_i,
   output logic [WORD_W-1:0] rword_o,
   output logic              viol_o
);
   logic [WORD_W-1:0] mem_q [DEPTH];
   logic [DEPTH-1:0]  tag_q;
   logic [WORD_W-1:0] word, just;
   logic              blocked;
   half_sel_e         sel;

   assign sel     = half_sel_e'(sel_i);
   assign word    = mem_q[addr_i];
   assign blocked = tag_q[addr_i] & ~ifp_i;

   // Per-half write enables keep the unselected half and its parity intact.
   always_ff @(posedge clk) begin
      if (acc_i && we_i) begin
         if (sel_i[1]) mem_q[addr_i][WORD_W-1:HALF_W] <= wword_i[WORD_W-1:HALF_W];
         if (sel_i[0]) mem_q[addr_i][HALF_W-1:0]      <= wword_i[HALF_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tag_q <= '0;
      end else if (acc_i && we_i && sel != HS_NONE) begin
         tag_q[addr_i] <= ins_i;
      end
   end

   always_comb begin
      case (sel)
         HS_BOTH:  just = word;
         HS_LEFT:  just = {{HALF_W{1'b0}}, word[WORD_W-1:HALF_W]};
         HS_RIGHT: just = {{HALF_W{1'b0}}, word[HALF_W-1:0]};
         default:  just = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rword_o <= '0;
         viol_o  <= 1'b0;
      end else if (acc_i && !we_i) begin
         viol_o  <= blocked;
         rword_o <= blocked ? '0 : just;
      end
   end

   AST_TAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_i && we_i && ins_i && sel_i != 2'b00) |=> tag_q[$past(addr_i)]); // R6
   AST_VIOL_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
      viol_o |-> (rword_o == '0)); // R7
endmodule

// File: rtl/halfsel_operand_store.sv
module halfsel_operand_store #(
   parameter int ADDR_W    = 10,
   parameter int HALF_DW   = 32,
   parameter int PAR_SLICE = 16,
   parameter int NUM_OPR   = 2,
   parameter int NUM_IO    = 2,
   parameter int BUSY_CYC  = 5,
   localparam int NDP    = NUM_OPR + NUM_IO,
   localparam int NPORT  = NDP + 1,
   localparam int PID_W  = $clog2(NPORT),
   localparam int PPH    = HALF_DW / PAR_SLICE,
   localparam int HALF_W = HALF_DW + PPH,
   localparam int WORD_W = 2 * HALF_W,
   localparam int WD_W   = 2 * HALF_DW,
   localparam int CNT_W  = $clog2(BUSY_CYC + 1)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       if_req,
   input  logic [ADDR_W-1:0]          if_addr,
   input  logic [1:0]                 if_sel,
   input  logic [NDP-1:0]             dp_req,
   input  logic [NDP-1:0]             dp_we,
   input  logic [NDP-1:0]             dp_ins,
   input  logic [NDP-1:0][1:0]        dp_sel,
   input  logic [NDP-1:0][ADDR_W-1:0] dp_addr,
   input  logic [NDP-1:0][WD_W-1:0]   dp_wdata,
   output logic                       if_gnt,
   output logic [NDP-1:0]             dp_gnt,
   output logic                       rsp_valid,
   output logic [PID_W-1:0]           rsp_port,
   output logic                       rsp_viol,
   output logic [WORD_W-1:0]          rsp_data
);
   if (BUSY_CYC < 2) begin : g_err_busy
      $error("halfsel_operand_store: BUSY_CYC must be at least 2");
   end
   if (NDP < 1) begin : g_err_ports
      $error("halfsel_operand_store: at least one data port expected");
   end

   logic [NPORT-1:0]  req_all, gnt_all;
   logic [PID_W-1:0]  win_idx;
   logic [CNT_W-1:0]  cnt_q;
   logic              busy, acc;
   logic              rd_q;
   logic [PID_W-1:0]  port_q;
   logic              bank_viol;

   logic [ADDR_W-1:0] m_addr;
   logic [1:0]        m_sel;
   logic              m_we, m_ins;
   logic [WD_W-1:0]   m_wd;
   logic [WORD_W-1:0] m_word;

   assign req_all = {dp_req, if_req};
   assign busy    = (cnt_q != '0);
   assign acc     = |gnt_all;
   assign if_gnt  = gnt_all[0];
   assign dp_gnt  = gnt_all[NPORT-1:1];

   hos_arbiter #(.N(NPORT)) u_arb (
      .en_i  (~busy),
      .req_i (req_all),
      .gnt_o (gnt_all),
      .idx_o (win_idx)
   );

   // Route the fields of the granted port to the array.
   always_comb begin
      m_addr = if_addr;
      m_sel  = if_sel;
      m_we   = 1'b0;
      m_ins  = 1'b0;
      m_wd   = '0;
      for (int k = 0; k < NDP; k++) begin
         if (gnt_all[k+1]) begin
            m_addr = dp_addr[k];
            m_sel  = dp_sel[k];
            m_we   = dp_we[k];
            m_ins  = dp_ins[k];
            m_wd   = dp_wdata[k];
         end
      end
   end

   for (genvar h = 0; h < 2; h++) begin : g_half
      logic [PPH-1:0] par;
      hos_parity_gen #(.DW(HALF_DW), .SLICE(PAR_SLICE)) u_par (
         .data_i (m_wd[h*HALF_DW +: HALF_DW]),
         .par_o  (par)
      );
      assign m_word[h*HALF_W +: HALF_W] = {par, m_wd[h*HALF_DW +: HALF_DW]};
   end

   hos_bank #(.ADDR_W(ADDR_W), .HALF_W(HALF_W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .acc_i   (acc),
      .we_i    (m_we),
      .ins_i   (m_ins),
      .ifp_i   (gnt_all[0]),
      .sel_i   (m_sel),
      .addr_i  (m_addr),
      .wword_i (m_word),
      .rword_o (rsp_data),
      .viol_o  (bank_viol)
   );

   // Busy window counter and response bookkeeping.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         rd_q   <= 1'b0;
         port_q <= '0;
      end else if (acc) begin
         cnt_q  <= CNT_W'(BUSY_CYC - 1);
         rd_q   <= ~m_we;
         port_q <= win_idx;
      end else if (busy) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign rsp_valid = (cnt_q == CNT_W'(1)) & rd_q;
   assign rsp_port  = port_q;
   assign rsp_viol  = rsp_valid & bank_viol;

   AST_NO_GNT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (gnt_all == '0)); // R9
   AST_BUSY_AFTER_GNT: assert property (@(posedge clk) disable iff (!rst_n)
      acc |=> busy); // R9
   AST_IF_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && if_req) |-> if_gnt); // R8
   AST_ONE_GNT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt_all)); // R8
   AST_GNT_ONLY_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_all & ~req_all) == '0); // R8
   AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid); // R10
   AST_IF_NO_VIOL: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_port == '0) |-> !rsp_viol); // R7

   for (genvar h = 0; h < 2; h++) begin : g_chk
      for (genvar j = 0; j < PPH; j++) begin : g_sl
         AST_RSP_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
            rsp_valid |-> ((^rsp_data[h*HALF_W + j*PAR_SLICE +: PAR_SLICE])
                           == rsp_data[h*HALF_W + HALF_DW + j])); // R2
      end
   end
endmodule

// File: tb/halfsel_operand_store_tb_top.sv
`timescale 1ns/1ps
module halfsel_operand_store_tb_top;
   localparam int ADDR_W = 10;
   localparam int DEPTH  = 1 << ADDR_W;
   localparam int NDP    = 4;
   localparam int BUSY   = 5;
   localparam int WW     = 68;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic                       if_req = 1'b0;
   logic [ADDR_W-1:0]          if_addr = '0;
   logic [1:0]                 if_sel = 2'b11;
   logic [NDP-1:0]             dp_req = '0;
   logic [NDP-1:0]             dp_we = '0;
   logic [NDP-1:0]             dp_ins = '0;
   logic [NDP-1:0][1:0]        dp_sel = '0;
   logic [NDP-1:0][ADDR_W-1:0] dp_addr = '0;
   logic [NDP-1:0][63:0]       dp_wdata = '0;
   logic                       if_gnt;
   logic [NDP-1:0]             dp_gnt;
   logic                       rsp_valid;
   logic [2:0]                 rsp_port;
   logic                       rsp_viol;
   logic [WW-1:0]              rsp_data;

   halfsel_operand_store dut_i (
      .clk(clk), .rst_n(rst_n),
      .if_req(if_req), .if_addr(if_addr), .if_sel(if_sel),
      .dp_req(dp_req), .dp_we(dp_we), .dp_ins(dp_ins), .dp_sel(dp_sel),
      .dp_addr(dp_addr), .dp_wdata(dp_wdata),
      .if_gnt(if_gnt), .dp_gnt(dp_gnt),
      .rsp_valid(rsp_valid), .rsp_port(rsp_port), .rsp_viol(rsp_viol),
      .rsp_data(rsp_data)
   );

   int checks = 0;
   int failures = 0;

   // Reference model state
   logic [WW-1:0]    m_mem [DEPTH];
   bit   [DEPTH-1:0] m_tag;
   int               m_cnt = 0;
   bit               m_rd = 0;
   int               m_port = 0;
   bit               m_viol = 0;
   logic [WW-1:0]    m_data = '0;

   function automatic logic [33:0] mk_half(input logic [31:0] d);
      logic [1:0] p = 2'b00;
      for (int b = 0; b < 32; b++) p[b/16] = p[b/16] ^ d[b];
      return {p, d};
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [WW-1:0] act, input logic [WW-1:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h t=%0t", req, what, act, exp, $time);
      end
   endtask

   // One clock: compare outputs with the model, advance the model, retire grants.
   task automatic step();
      int win = -1;
      logic ewe, eins;
      logic [1:0] esel;
      int eaddr;
      logic [63:0] ewd;
      logic [NDP-1:0] edp = '0;
      logic [WW-1:0] w, j;
      bit erv, vi;
      #1;
      if (m_cnt == 0) begin
         if (if_req) win = 0;
         else for (int k = 0; k < NDP; k++) if (dp_req[k] && win < 0) win = k + 1;
      end
      if (win > 0) edp[win-1] = 1'b1;
      erv = (m_cnt == 1) && m_rd;
      chk("R8 R9", "if_gnt", WW'(if_gnt), WW'(win == 0));
      chk("R8 R9", "dp_gnt", WW'(dp_gnt), WW'(edp));
      chk("R10", "rsp_valid", WW'(rsp_valid), WW'(erv));
      if (erv) begin
         chk("R10", "rsp_port", WW'(rsp_port), WW'(m_port));
         chk("R7", "rsp_viol", WW'(rsp_viol), WW'(m_viol));
         chk("R2 R3 R4 R5 R7 R11", "rsp_data", rsp_data, m_data);
      end
      if (m_cnt > 0) m_cnt--;
      if (win >= 0) begin
         if (win == 0) begin
            ewe = 0; eins = 0; esel = if_sel; eaddr = int'(if_addr); ewd = '0;
         end else begin
            ewe = dp_we[win-1]; eins = dp_ins[win-1]; esel = dp_sel[win-1];
            eaddr = int'(dp_addr[win-1]); ewd = dp_wdata[win-1];
         end
         if (ewe) begin
            if (esel[1]) m_mem[eaddr][67:34] = mk_half(ewd[63:32]);
            if (esel[0]) m_mem[eaddr][33:0]  = mk_half(ewd[31:0]);
            if (esel != 2'b00) m_tag[eaddr] = eins;
         end else begin
            vi = m_tag[eaddr] && (win != 0);
            w = m_mem[eaddr];
            case (esel)
               2'b11: j = w;
               2'b10: j = {34'b0, w[67:34]};
               2'b01: j = {34'b0, w[33:0]};
               default: j = '0;
            endcase
            m_viol = vi;
            m_data = vi ? '0 : j;
            m_port = win;
         end
         m_rd = !ewe;
         m_cnt = BUSY - 1;
      end
      @(posedge clk);
      @(negedge clk);
      if (win == 0) if_req = 1'b0;
      else if (win > 0) dp_req[win-1] = 1'b0;
   endtask

   task automatic put(input int p, input logic we, input logic ins, input logic [1:0] sel,
                      input int addr, input logic [63:0] wd);
      if (p == 0) begin
         if_req = 1'b1; if_sel = sel; if_addr = ADDR_W'(addr);
      end else begin
         dp_req[p-1] = 1'b1; dp_we[p-1] = we; dp_ins[p-1] = ins;
         dp_sel[p-1] = sel; dp_addr[p-1] = ADDR_W'(addr); dp_wdata[p-1] = wd;
      end
   endtask

   task automatic drain();
      while (if_req || dp_req != '0 || m_cnt != 0) step();
   endtask

   task automatic do_reset();
      if_req = 1'b0; dp_req = '0; rst_n = 1'b0;
      repeat (3) @(negedge clk);
      m_cnt = 0; m_rd = 0; m_tag = '0;
      rst_n = 1'b1;
      #1;
      chk("R1", "rsp_valid after reset", WW'(rsp_valid), '0);
      chk("R1", "grants after reset", WW'({dp_gnt, if_gnt}), '0);
      @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++; failures++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      do_reset();
      // R2 R11: whole-word stores from every data port, fetched from every port
      for (int i = 0; i < 8; i++) begin
         put(1 + (i % NDP), 1, 0, 2'b11, i, {32'h9E3779B9 * i, ~(32'h0F1E2D3C + i)});
         drain();
      end
      put(1, 1, 0, 2'b11, 8, 64'hFFFF_FFFF_FFFF_FFFF); drain();
      put(2, 1, 0, 2'b11, 9, 64'hAAAA_5555_0000_0001); drain();
      for (int i = 0; i < 10; i++) begin
         put(i % (NDP + 1), 0, 0, 2'b11, i, '0);
         drain();
      end
      // R3: half stores keep the other half
      put(2, 1, 0, 2'b10, 3, {32'hFFFF_0001, 32'hDEAD_BEEF}); drain();
      put(0, 0, 0, 2'b11, 3, '0); drain();
      put(3, 1, 0, 2'b01, 4, {32'h1234_5678, 32'h8000_0001}); drain();
      put(4, 0, 0, 2'b11, 4, '0); drain();
      // R4: half fetches right-justified
      put(1, 0, 0, 2'b10, 5, '0); drain();
      put(4, 0, 0, 2'b01, 5, '0); drain();
      put(0, 0, 0, 2'b10, 8, '0); drain();
      // R5: empty select
      put(1, 1, 0, 2'b00, 7, 64'hFFFF_FFFF_FFFF_FFFF); drain();
      put(2, 0, 0, 2'b11, 7, '0); drain();
      put(2, 0, 0, 2'b00, 7, '0); drain();
      // R6 R7: instruction tag, then a data store clears it
      put(3, 1, 1, 2'b11, 10, 64'hCAFE_F00D_0BAD_C0DE); drain();
      put(1, 0, 0, 2'b11, 10, '0); drain();
      put(4, 0, 0, 2'b01, 10, '0); drain();
      put(0, 0, 0, 2'b11, 10, '0); drain();
      put(1, 1, 1, 2'b00, 9, '0); drain();  // R5 R6: empty select leaves tag clear
      put(2, 0, 0, 2'b11, 9, '0); drain();
      put(2, 1, 0, 2'b10, 10, 64'h7777_0000_0000_0000); drain();
      put(1, 0, 0, 2'b11, 10, '0); drain();
      put(4, 1, 1, 2'b01, 11, 64'h0000_0000_1357_9BDF); drain();
      put(0, 0, 0, 2'b01, 11, '0); drain();
      put(3, 0, 0, 2'b01, 11, '0); drain();
      // R8 R9: all ports at once
      put(4, 0, 0, 2'b11, 1, '0); put(3, 0, 0, 2'b10, 2, '0); put(2, 0, 0, 2'b11, 6, '0);
      put(1, 0, 0, 2'b01, 0, '0); put(0, 0, 0, 2'b11, 5, '0);
      drain();
      // R8 R11: data ports only, store then fetch through arbitration order
      put(3, 0, 0, 2'b11, 12, '0); put(2, 1, 0, 2'b11, 12, 64'h0F0F_0F0F_F0F0_F0F0);
      put(4, 0, 0, 2'b11, 12, '0);
      drain();
      // R9: request arriving while busy waits; higher priority arrives later
      put(4, 0, 0, 2'b11, 6, '0); step(); step();
      put(0, 0, 0, 2'b11, 7, '0); put(3, 0, 0, 2'b10, 7, '0);
      drain();
      // R1: reset clears tags, contents kept
      put(1, 1, 1, 2'b11, 13, 64'h0123_4567_89AB_CDEF); drain();
      put(2, 0, 0, 2'b11, 13, '0); drain();
      do_reset();
      put(2, 0, 0, 2'b11, 13, '0); drain();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule